// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block builds a 24-bit Hamming code over one 512-byte NAND sector while the bytes stream past. The code corrects one flipped bit and detects two. Each data bit has a 12-bit address, formed as byte_index*8 + bit_index. For each address bit the block keeps two running parities. The "odd" member of the pair folds in every set data bit whose address has a 1 in that position. The "even" member folds in every set data bit whose address has a 0 there. Address bits 0 to 2 carry the weights 1, 2 and 4 and pick the bit within the byte. Address bits 3 to 11 carry the weights 8 to 2048 and pick the byte within the sector.

A start-of-sector strobe begins a new sector, and the byte presented with it becomes byte 0. A clear strobe empties the accumulator. When byte 511 has been taken, the block raises a one-cycle done strobe. It then holds the result until the next clear or start-of-sector. The result is presented in two forms: a 32-bit word that holds the raw pairs, and a packed 3-byte code. In the packed code every pair is inverted, so an all-zero sector packs to all ones. A 2048-byte page is coded as four consecutive sectors, each with its own code.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, parity_word is zero, done is low and code is 24'hFFFFFF.
- R2: The bit-position parities use pair index 0, 1 and 2 for the weights 1, 2 and 4. The odd member of pair k is the XOR of the data bits whose bit index has bit k set. The even member is the XOR of the data bits whose bit index has bit k clear. Every accepted byte of the sector counts.
- R3: The byte-position parities use pair index k+3 (k = 0..8) for the weights 8 to 2048. The odd member is the XOR of all bits of those bytes whose byte index has bit k set. The even member is the XOR of all bits of those bytes whose byte index has bit k clear.
- R4: parity_word carries the even members of pairs 0..11 in bits 0..11 and the odd members in bits 16..27. Bits 12..15 and 28..31 are zero.
- R5: code holds three bytes, and every bit of code is the inverse of its parity. Writing e[k] and o[k] for the members of pair k, code[7:0] = ~{o6,e6,o5,e5,o4,e4,o3,e3}, code[15:8] = ~{o10,e10,o9,e9,o8,e8,o7,e7} and code[23:16] = ~{o2,e2,o1,e1,o0,e0,o11,e11}. In each group the left element is the most significant bit.
- R6: done is high for exactly the one cycle after the clock edge that accepts byte 511. After that, valid bytes without sos are ignored, and parity_word and code hold until clr or sos.
- R7: clr zeroes all pairs and the byte count, and the byte presented in the same cycle is dropped. The next 512 valid bytes form a full sector even without sos.
- R8: sos zeroes all pairs and the byte count, and a valid byte in the same cycle is taken as byte 0. This aborts any partial sector.
- R9: Cycles with valid low change neither the result nor the byte count. The same bytes give the same code whatever gaps separate them.
- R10: Back-to-back sectors that each begin with sos produce one independent code per sector, so a 2048-byte page yields four codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Clear accumulator and byte count |
| sos | input | 1 | Start of sector; the byte presented with it is byte 0 |
| valid | input | 1 | data carries a byte this cycle |
| data | input | 8 | Sector byte |
| done | output | 1 | One-cycle strobe after byte 511 is accepted |
| parity_word | output | 32 | Raw pairs: even members in bits 11:0, odd members in bits 27:16 |
| code | output | 24 | Packed, inverted 3-byte code |

## Verification
The bench places a single flipped bit at byte 300, bit 5. It then checks that the odd half spells address 2405 and the even half spells its complement. A design with a swapped pair or a wrong weight would show up there as a wrong address. The bench feeds the same random sector twice, once with random gaps and once without. A design that counted a stalled cycle as a byte would give two different codes or a late done. It also aborts a partial sector with sos, cuts one short with clr, sends bytes after done, and runs a four-sector page. These cases catch stale parity carried across a restart, a count that does not clear, and a code that changes after completion.

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        sos,
  input  logic        valid,
  input  logic [7:0]  data,
  output logic        done,
  output logic [31:0] parity_word,
  output logic [23:0] code
);
  localparam int SECTOR_BYTES = 512;
  localparam int IDX_W = $clog2(SECTOR_BYTES);
  localparam int NP = 3 + IDX_W;

  logic [NP-1:0]    pe, po, ne, no;
  logic [IDX_W:0]   cnt;
  logic [IDX_W-1:0] idx;
  logic             accept, bpar;

  assign accept = valid && !clr && (sos || !cnt[IDX_W]);
  assign idx    = sos ? '0 : cnt[IDX_W-1:0];
  assign bpar   = ^data;

  always_comb begin
    ne = sos ? '0 : pe;
    no = sos ? '0 : po;
    if (accept) begin
      ne[0] = ne[0] ^ (^(data & 8'h55));
      no[0] = no[0] ^ (^(data & 8'hAA));
      ne[1] = ne[1] ^ (^(data & 8'h33));
      no[1] = no[1] ^ (^(data & 8'hCC));
      ne[2] = ne[2] ^ (^(data & 8'h0F));
      no[2] = no[2] ^ (^(data & 8'hF0));
      for (int k = 0; k < IDX_W; k++) begin
        if (idx[k]) no[k+3] = no[k+3] ^ bpar;
        else        ne[k+3] = ne[k+3] ^ bpar;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe   <= '0;
      po   <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (clr) begin
      pe   <= '0;
      po   <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      pe   <= ne;
      po   <= no;
      cnt  <= accept ? {1'b0, idx} + 1'b1 : (sos ? '0 : cnt);
      done <= accept && (&idx);
    end
  end

  assign parity_word = {{(16-NP){1'b0}}, po, {(16-NP){1'b0}}, pe};

  assign code[7:0]   = ~{po[6], pe[6], po[5], pe[5], po[4], pe[4], po[3], pe[3]};
  assign code[15:8]  = ~{po[10], pe[10], po[9], pe[9], po[8], pe[8], po[7], pe[7]};
  assign code[23:16] = ~{po[2], pe[2], po[1], pe[1], po[0], pe[0], po[11], pe[11]};
endmodule

module nand_ecc_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        sos,
  input logic        valid,
  input logic        done,
  input logic [31:0] parity_word
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr && !sos |=> $stable(parity_word));
  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> parity_word == 32'h0);
  // R8
  sos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sos && !valid && !clr |=> parity_word == 32'h0);
  // R9
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !clr && !sos |=> $stable(parity_word));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk u_chk (.*);

// File: tb/sim_nand_ecc_gen.sv
`timescale 1ns/100ps
module sim_nand_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, sos = 1'b0, valid = 1'b0;
  logic [7:0]  data = 8'h00;
  logic        done;
  logic [31:0] parity_word;
  logic [23:0] code;

  int errors = 0;
  int checks = 0;
  logic [7:0]  sect [512];
  logic [55:0] expq [$];
  logic [55:0] last_exp;
  logic        last_done = 1'b0;
  int          done_seen = 0;
  logic [31:0] lfsr = 32'h1BADF00D;
  logic [23:0] code_a;

  nand_ecc_gen u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .sos(sos), .valid(valid),
                   .data(data), .done(done), .parity_word(parity_word), .code(code));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] model();
    logic [11:0] e = '0, o = '0;
    logic [11:0] a;
    logic [23:0] c;
    for (int n = 0; n < 4096; n++) begin
      a = n[11:0];
      if (sect[n/8][n%8])
        for (int w = 0; w < 12; w++)
          if (a[w]) o[w] = ~o[w]; else e[w] = ~e[w];
    end
    c[7:0]   = ~{o[6], e[6], o[5], e[5], o[4], e[4], o[3], e[3]};
    c[15:8]  = ~{o[10], e[10], o[9], e[9], o[8], e[8], o[7], e[7]};
    c[23:16] = ~{o[2], e[2], o[1], e[1], o[0], e[0], o[11], e[11]};
    return {4'h0, o, 4'h0, e, c};
  endfunction

  function automatic logic [7:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[7:0] ^ lfsr[23:16];
  endfunction

  task automatic send(input int n, input bit with_sos, input bit stalls, input bit push);
    if (push) begin
      last_exp = model();
      expq.push_back(last_exp);
    end
    for (int i = 0; i < n; i++) begin
      if (stalls && (rnd() % 4 == 0)) begin
        int g = 1 + rnd() % 3;
        for (int s = 0; s < g; s++) begin
          @(negedge clk); valid = 1'b0; sos = 1'b0;
        end
      end
      @(negedge clk);
      valid = 1'b1; data = sect[i]; sos = with_sos && (i == 0);
    end
    @(negedge clk); valid = 1'b0; sos = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (last_done) chk("R6 done one cycle", {55'h0, done}, 56'h0);
      if (done) begin
        done_seen++;
        if (expq.size() == 0) chk("R10 unexpected done", 56'h1, 56'h0);
        else chk("R2 R3 R4 R5 sector result", {parity_word, code}, expq.pop_front());
      end
      last_done <= done;
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset word", {24'h0, parity_word}, 56'h0);
    chk("R1 reset done", {55'h0, done}, 56'h0);
    chk("R1 reset code", {32'h0, code}, {32'h0, 24'hFFFFFF});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 512; i++) sect[i] = 8'h00;
    send(512, 1, 0, 1);
    chk("R5 zero sector code", {32'h0, code}, {32'h0, 24'hFFFFFF});

    for (int i = 0; i < 512; i++) sect[i] = 8'hFF;
    send(512, 1, 0, 1);

    for (int i = 0; i < 512; i++) sect[i] = i[7:0];
    send(512, 1, 0, 1);

    // R2 R3: single bit at byte 300 bit 5 gives address 2405
    for (int i = 0; i < 512; i++) sect[i] = 8'h00;
    sect[300] = 8'h20;
    send(512, 1, 0, 1);
    chk("R3 odd half address", {44'h0, parity_word[27:16]}, {44'h0, 12'd2405});
    chk("R2 even half complement", {44'h0, parity_word[11:0]}, {44'h0, ~12'd2405});
    chk("R4 zero gaps", {48'h0, parity_word[31:28], parity_word[15:12]}, 56'h0);

    // R9: same random data with and without stalls
    for (int i = 0; i < 512; i++) sect[i] = rnd();
    send(512, 1, 1, 1);
    code_a = code;
    send(512, 1, 0, 1);
    chk("R9 stall invariance", {32'h0, code}, {32'h0, code_a});

    // R6: bytes after done are ignored
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); valid = 1'b1; data = 8'hA5;
    end
    @(negedge clk); valid = 1'b0;
    @(negedge clk);
    chk("R6 hold after done", {parity_word, code}, last_exp);

    // R8: abort a partial sector with sos
    for (int i = 0; i < 512; i++) sect[i] = rnd();
    send(100, 1, 0, 0);
    for (int i = 0; i < 512; i++) sect[i] = rnd();
    send(512, 1, 0, 1);
    chk("R8 restart result", {parity_word, code}, last_exp);

    // R7: clr mid-sector, then full sector without sos
    send(200, 1, 0, 0);
    @(negedge clk); clr = 1'b1; valid = 1'b1; data = 8'hFF;
    @(negedge clk); clr = 1'b0; valid = 1'b0;
    chk("R7 clr zero word", {24'h0, parity_word}, 56'h0);
    chk("R7 clr code", {32'h0, code}, {32'h0, 24'hFFFFFF});
    for (int i = 0; i < 512; i++) sect[i] = rnd();
    send(512, 0, 1, 1);
    chk("R7 count cleared", {parity_word, code}, last_exp);

    // R10: four-sector page
    done_seen = 0;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 512; i++) sect[i] = rnd() ^ s[7:0];
      send(512, 1, s[0], 1);
    end
    chk("R10 four codes", {24'h0, done_seen}, 56'd4);
    chk("R10 queue drained", {24'h0, expq.size()}, 56'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule